// File: doc/BRIEF.md
# Receive Queue with Interrupt Cause Register

This block buffers frames delivered by a serial receiver until software reads them. It also keeps a 12-bit interrupt-cause vector that shows the queue's fill state and records error and protocol events. The receiver presents one frame per cycle on a write strobe, and the software side pops one entry per read request. The cause vector, gated by a per-bit enable mask, drives a single interrupt request line.

Each entry can hold 8, 16 or 32 bits, selected by an entry-width setting. The storage stays the same size, so the usable queue depth is halved each time the entry width doubles. Changing the width setting empties the queue. Three cause bits follow the queue level: above-threshold, not-empty and full. The other cause bits are sticky. They record lost writes, reads from an empty queue, and four receiver events, and software clears them by writing ones.

Top module: `rxq_top`

## Requirements
- R1: After reset the cause vector, the interrupt request and the read data are all zero, and the queue is empty with entry width 0.
- R2: Entries come out in the order they were written. A read of a non-empty queue places the oldest entry on rdData in the cycle after the request.
- R3: Entry width setting 0 stores 8 bits (upper bits read as zero) with capacity DEPTH. Setting 1 stores 16 bits with capacity DEPTH/2. Settings 2 and 3 store 32 bits with capacity DEPTH/4.
- R4: Cause bit 0 is 1 exactly when the number of stored entries is strictly greater than trigLevel.
- R5: Cause bit 2 is 1 when the queue holds at least one entry, and cause bit 3 is 1 when it holds the capacity of the current width setting. Bits 1 and 4 always read zero.
- R6: A write while the queue is full is discarded, the stored contents are unchanged, and sticky bit 5 is set.
- R7: A read while the queue is empty sets sticky bit 6, loads zero into rdData and moves no pointer.
- R8: evtIn bits 0, 1, 2 and 3 (frame error, parity error, baud-rate detected, break detected) set sticky cause bits 8, 9, 10 and 11.
- R9: When clrWe is high, each clrData bit at 1 clears the matching sticky bit, and bits at 0 have no effect. An event in the same cycle as its clear leaves the bit set. Clearing bits 0, 2 or 3 has no effect while their condition holds.
- R10: irqOut is 1 exactly when some cause bit is 1 and its maskIn bit is 1.
- R11: In the cycle in which widthMode differs from its value in the previous cycle, the queue is emptied. Any write or read in that cycle is ignored, raises no event and leaves rdData unchanged.
- R12: Full and empty are judged on the content at the start of the cycle. A read plus a write on a full queue pops the oldest entry and drops the new frame with overflow. A read plus a write on an empty queue underflows and stores the new frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| widthMode | input | 2 | Entry width setting (0: 8 bit, 1: 16 bit, 2/3: 32 bit) |
| trigLevel | input | CNT_W | Threshold for cause bit 0 |
| wrValid | input | 1 | Frame write strobe from the receiver |
| wrData | input | DATA_W | Frame data |
| rdReq | input | 1 | Software pop request |
| rdData | output | DATA_W | Popped entry, valid the cycle after rdReq |
| evtIn | input | 4 | Receiver event pulses (frame, parity, baud, break) |
| clrWe | input | 1 | Write-one-to-clear strobe for the cause vector |
| clrData | input | 12 | Clear pattern |
| maskIn | input | 12 | Interrupt enable per cause bit |
| causeOut | output | 12 | Interrupt cause vector |
| irqOut | output | 1 | Masked interrupt request |

## Verification
Several functions can coincide in one cycle, and the bench provokes each such pair. A clear strobe can meet the event it clears: the bench raises an event pulse and a clear of the same bit together, and the bit must stay set. A push can meet a pop at the full and empty boundaries: there the bench expects an overflow with a pop, or an underflow with a store. A width change can meet a write or read: the bench expects the flush to swallow both. A queue model in the bench computes the expected cause vector, interrupt and read data for every cycle, for both the directed corners and a long seeded random mix.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  localparam int CAUSE_W = 12;
  localparam int EVT_W   = 4;

  localparam int B_TRIG   = 0;
  localparam int B_NEMPTY = 2;
  localparam int B_FULL   = 3;
  localparam int B_OVF    = 5;
  localparam int B_UNF    = 6;
  localparam int B_EVT0   = 8;

  localparam logic [CAUSE_W-1:0] STICKY_MASK = 12'hFE0;

  typedef struct packed {
    logic push;
    logic pop;
    logic emptyRead;
  } fifoStrb_t;

  // number of shift steps applied to depth and number of byte lanes kept
  function automatic logic [1:0] shiftFor(input logic [1:0] mode);
    return (mode == 2'd0) ? 2'd0 : (mode == 2'd1) ? 2'd1 : 2'd2;
  endfunction

  function automatic int lanesFor(input logic [1:0] mode);
    return 1 << shiftFor(mode);
  endfunction
endpackage

// File: rtl/rxq_ctrl.sv
module rxq_ctrl
  import rxq_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int IDX_W = $clog2(DEPTH),
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       widthMode,
  input  logic             wrValid,
  input  logic             rdReq,
  output fifoStrb_t        strb,
  output logic [IDX_W-1:0] wrIdx,
  output logic [IDX_W-1:0] rdIdx,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] capacity,
  output logic             ovfEvt,
  output logic             unfEvt
);
  logic [1:0]       modeQ;
  logic             modeChg;
  logic             isFull;
  logic             isEmpty;
  logic [IDX_W-1:0] wrPtr;
  logic [IDX_W-1:0] rdPtr;
  logic [CNT_W-1:0] countQ;
  logic [CNT_W-1:0] lastIdx;

  assign modeChg  = (widthMode != modeQ);
  assign capacity = CNT_W'(DEPTH) >> shiftFor(modeQ);
  assign lastIdx  = capacity - CNT_W'(1);
  assign isFull   = (countQ == capacity);
  assign isEmpty  = (countQ == '0);

  always_comb begin
    strb.push      = wrValid && !isFull && !modeChg;
    strb.pop       = rdReq && !isEmpty && !modeChg;
    strb.emptyRead = rdReq && isEmpty && !modeChg;
  end

  assign ovfEvt = wrValid && isFull && !modeChg;
  assign unfEvt = strb.emptyRead;
  assign wrIdx  = wrPtr;
  assign rdIdx  = rdPtr;
  assign count  = countQ;

  function automatic logic [IDX_W-1:0] bump(input logic [IDX_W-1:0] p,
                                            input logic [CNT_W-1:0] last);
    return (CNT_W'(p) == last) ? '0 : p + IDX_W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeQ  <= 2'd0;
      wrPtr  <= '0;
      rdPtr  <= '0;
      countQ <= '0;
    end else if (modeChg) begin
      modeQ  <= widthMode;
      wrPtr  <= '0;
      rdPtr  <= '0;
      countQ <= '0;
    end else begin
      if (strb.push) wrPtr <= bump(wrPtr, lastIdx);
      if (strb.pop)  rdPtr <= bump(rdPtr, lastIdx);
      case ({strb.push, strb.pop})
        2'b10:   countQ <= countQ + CNT_W'(1);
        2'b01:   countQ <= countQ - CNT_W'(1);
        default: countQ <= countQ;
      endcase
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    countQ <= capacity); // R3
  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    modeChg |=> (countQ == '0)); // R11
  AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && !rdReq && !modeChg && isFull) |=> (countQ == $past(countQ))); // R6
  AST_EMPTY_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (rdReq && !wrValid && !modeChg && isEmpty) |=> (countQ == '0 && rdPtr == $past(rdPtr))); // R7
endmodule

// File: rtl/rxq_dpath.sv
module rxq_dpath
  import rxq_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 32,
  parameter int IDX_W  = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        widthMode,
  input  fifoStrb_t         strb,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [IDX_W-1:0]  rdIdx,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData
);
  localparam int LANES = DATA_W / 8;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] maskedData;
  logic [DATA_W-1:0] rdQ;

  // byte lanes above the selected entry width are stored as zero
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign maskedData[l*8 +: 8] = (l < lanesFor(widthMode)) ? wrData[l*8 +: 8] : 8'h00;
  end

  always_ff @(posedge clk) begin
    if (strb.push) mem[wrIdx] <= maskedData;
  end

  always_ff @(posedge clk) begin
    if (!rstN)               rdQ <= '0;
    else if (strb.pop)       rdQ <= mem[rdIdx];
    else if (strb.emptyRead) rdQ <= '0;
  end

  assign rdData = rdQ;

  AST_EMPTY_RD_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    strb.emptyRead |=> (rdData == '0)); // R7
  AST_NO_PUSH_POP_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.pop && strb.emptyRead)); // R12
endmodule

// File: rtl/rxq_cause.sv
module rxq_cause
  import rxq_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [CNT_W-1:0]   count,
  input  logic [CNT_W-1:0]   capacity,
  input  logic [CNT_W-1:0]   trigLevel,
  input  logic               ovfEvt,
  input  logic               unfEvt,
  input  logic [EVT_W-1:0]   evtIn,
  input  logic               clrWe,
  input  logic [CAUSE_W-1:0] clrData,
  input  logic [CAUSE_W-1:0] maskIn,
  output logic [CAUSE_W-1:0] causeOut,
  output logic               irqOut
);
  logic [CAUSE_W-1:0] stickyQ;
  logic [CAUSE_W-1:0] setVec;
  logic [CAUSE_W-1:0] clrVec;
  logic [CAUSE_W-1:0] levelVec;

  always_comb begin
    setVec = '0;
    setVec[B_OVF] = ovfEvt;
    setVec[B_UNF] = unfEvt;
    for (int e = 0; e < EVT_W; e++) setVec[B_EVT0 + e] = evtIn[e];
    clrVec = clrWe ? clrData : '0;
  end

  always_comb begin
    levelVec = '0;
    levelVec[B_TRIG]   = (count > trigLevel);
    levelVec[B_NEMPTY] = (count != '0);
    levelVec[B_FULL]   = (count == capacity);
  end

  always_ff @(posedge clk) begin
    if (!rstN) stickyQ <= '0;
    else       stickyQ <= ((stickyQ & ~clrVec) | setVec) & STICKY_MASK;
  end

  assign causeOut = stickyQ | levelVec;
  assign irqOut   = |(causeOut & maskIn);

  AST_EVT_FRAME: assert property (@(posedge clk) disable iff (!rstN)
    evtIn[0] |=> causeOut[B_EVT0]); // R8
  AST_STICKY_KEEP: assert property (@(posedge clk) disable iff (!rstN)
    !clrWe |=> ((causeOut & STICKY_MASK & $past(causeOut)) == ($past(causeOut) & STICKY_MASK))); // R9
  AST_FULL_NEMPTY: assert property (@(posedge clk) disable iff (!rstN)
    causeOut[B_FULL] |-> causeOut[B_NEMPTY]); // R5
  AST_OVF_SET: assert property (@(posedge clk) disable iff (!rstN)
    ovfEvt |=> causeOut[B_OVF]); // R6
endmodule

// File: rtl/rxq_top.sv
module rxq_top
  import rxq_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 32,
  parameter int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [1:0]         widthMode,
  input  logic [CNT_W-1:0]   trigLevel,
  input  logic               wrValid,
  input  logic [DATA_W-1:0]  wrData,
  input  logic               rdReq,
  output logic [DATA_W-1:0]  rdData,
  input  logic [EVT_W-1:0]   evtIn,
  input  logic               clrWe,
  input  logic [CAUSE_W-1:0] clrData,
  input  logic [CAUSE_W-1:0] maskIn,
  output logic [CAUSE_W-1:0] causeOut,
  output logic               irqOut
);
  localparam int IDX_W = $clog2(DEPTH);

  fifoStrb_t        strb;
  logic [IDX_W-1:0] wrIdx;
  logic [IDX_W-1:0] rdIdx;
  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] capacity;
  logic             ovfEvt;
  logic             unfEvt;

  rxq_ctrl #(.DEPTH(DEPTH), .IDX_W(IDX_W), .CNT_W(CNT_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .widthMode(widthMode), .wrValid(wrValid), .rdReq(rdReq),
    .strb(strb), .wrIdx(wrIdx), .rdIdx(rdIdx), .count(count), .capacity(capacity),
    .ovfEvt(ovfEvt), .unfEvt(unfEvt)
  );

  rxq_dpath #(.DEPTH(DEPTH), .DATA_W(DATA_W), .IDX_W(IDX_W)) dpath_i (
    .clk(clk), .rstN(rstN), .widthMode(widthMode), .strb(strb), .wrIdx(wrIdx),
    .rdIdx(rdIdx), .wrData(wrData), .rdData(rdData)
  );

  rxq_cause #(.CNT_W(CNT_W)) cause_i (
    .clk(clk), .rstN(rstN), .count(count), .capacity(capacity), .trigLevel(trigLevel),
    .ovfEvt(ovfEvt), .unfEvt(unfEvt), .evtIn(evtIn), .clrWe(clrWe), .clrData(clrData),
    .maskIn(maskIn), .causeOut(causeOut), .irqOut(irqOut)
  );
endmodule

// File: tb/rxq_top_tb_top.sv
module rxq_top_tb_top;
  localparam int DEPTH = 16;

  logic        clk = 1'b0;
  logic        rstN;
  logic [1:0]  widthMode;
  logic [4:0]  trigLevel;
  logic        wrValid;
  logic [31:0] wrData;
  logic        rdReq;
  logic [31:0] rdData;
  logic [3:0]  evtIn;
  logic        clrWe;
  logic [11:0] clrData;
  logic [11:0] maskIn;
  logic [11:0] causeOut;
  logic        irqOut;

  int checks = 0;
  int errors = 0;

  logic [31:0] mq[$];
  logic [11:0] mSticky = '0;
  logic [1:0]  mMode = 2'd0;
  logic [31:0] mRd = '0;

  always #10 clk = ~clk;

  rxq_top dut_i (
    .clk(clk), .rstN(rstN), .widthMode(widthMode), .trigLevel(trigLevel),
    .wrValid(wrValid), .wrData(wrData), .rdReq(rdReq), .rdData(rdData),
    .evtIn(evtIn), .clrWe(clrWe), .clrData(clrData), .maskIn(maskIn),
    .causeOut(causeOut), .irqOut(irqOut)
  );

  function automatic int capOf(input logic [1:0] m);
    return DEPTH >> ((m == 2'd0) ? 0 : (m == 2'd1) ? 1 : 2);
  endfunction

  function automatic logic [31:0] widthMask(input logic [1:0] m);
    return (m == 2'd0) ? 32'h0000_00FF : (m == 2'd1) ? 32'h0000_FFFF : 32'hFFFF_FFFF;
  endfunction

  function automatic logic [11:0] expCause(input logic [4:0] tl);
    logic [11:0] c;
    c = mSticky;
    c[0] = (mq.size() > int'(tl));
    c[2] = (mq.size() != 0);
    c[3] = (mq.size() == capOf(mMode));
    return c;
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  task automatic step(input logic [1:0] md, input logic wv, input logic [31:0] wd,
                      input logic rr, input logic [3:0] ev, input logic cw,
                      input logic [11:0] cd, input logic [11:0] mk, input logic [4:0] tl,
                      input string tag);
    logic [11:0] setv;
    logic [11:0] ec;
    bit isFull;
    bit isEmpty;
    @(negedge clk);
    widthMode = md; wrValid = wv; wrData = wd; rdReq = rr; evtIn = ev;
    clrWe = cw; clrData = cd; maskIn = mk; trigLevel = tl;
    @(posedge clk);
    setv = '0;
    if (md != mMode) begin
      mq.delete();
      mMode = md;
    end else begin
      isFull  = (mq.size() == capOf(mMode));
      isEmpty = (mq.size() == 0);
      if (rr) begin
        if (isEmpty) begin
          setv[6] = 1'b1;
          mRd = '0;
        end else begin
          mRd = mq.pop_front();
        end
      end
      if (wv) begin
        if (isFull) setv[5] = 1'b1;
        else        mq.push_back(wd & widthMask(mMode));
      end
    end
    setv[11:8] = ev;
    mSticky = ((mSticky & ~(cw ? cd : 12'h000)) | setv) & 12'hFE0;
    #2;
    ec = expCause(tl);
    chk(causeOut == ec, tag, "cause", 32'(causeOut), 32'(ec));
    chk(irqOut == |(ec & mk), tag, "irq", 32'(irqOut), 32'(|(ec & mk)));
    chk(rdData == mRd, tag, "rdData", rdData, mRd);
  endtask

  task automatic idle(input logic [1:0] md, input logic [11:0] mk, input logic [4:0] tl,
                      input string tag);
    step(md, 1'b0, 32'h0, 1'b0, 4'h0, 1'b0, 12'h0, mk, tl, tag);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    int seedDummy;
    seedDummy = $urandom(32'd2024);
    rstN = 1'b0; widthMode = 2'd0; trigLevel = 5'd0; wrValid = 1'b0; wrData = '0;
    rdReq = 1'b0; evtIn = '0; clrWe = 1'b0; clrData = '0; maskIn = 12'hFFF;
    repeat (4) @(posedge clk);
    #2;
    chk(causeOut == 12'h0, "R1", "reset cause", 32'(causeOut), 32'h0);
    chk(irqOut == 1'b0, "R1", "reset irq", 32'(irqOut), 32'h0);
    chk(rdData == 32'h0, "R1", "reset rdData", rdData, 32'h0);
    @(negedge clk);
    rstN = 1'b1;
    idle(2'd0, 12'hFFF, 5'd0, "R1 after reset");

    // mode 0: fill past capacity, 8-bit entries
    for (int i = 0; i < DEPTH; i++)
      step(2'd0, 1'b1, 32'hA5A5_0000 + 32'(i * 17), 1'b0, 4'h0, 1'b0, 12'h0, 12'h001, 5'd3, "R3 R4 mode0 fill");
    step(2'd0, 1'b1, 32'hDEAD_BEEF, 1'b0, 4'h0, 1'b0, 12'h0, 12'h020, 5'd3, "R6 write when full");
    step(2'd0, 1'b1, 32'h1234_5678, 1'b1, 4'h0, 1'b0, 12'h0, 12'h008, 5'd3, "R12 full rd+wr");
    step(2'd0, 1'b0, 32'h0, 1'b0, 4'h0, 1'b1, 12'h00D, 12'h00D, 5'd3, "R9 level bits ignore clear");
    step(2'd0, 1'b0, 32'h0, 1'b0, 4'h0, 1'b1, 12'h020, 12'h020, 5'd3, "R9 clear overflow");
    for (int i = 0; i < DEPTH; i++)
      step(2'd0, 1'b0, 32'h0, 1'b1, 4'h0, 1'b0, 12'h0, 12'h004, 5'd15, "R2 R4 drain order");
    step(2'd0, 1'b1, 32'h0000_0077, 1'b1, 4'h0, 1'b0, 12'h0, 12'h040, 5'd0, "R12 empty rd+wr");
    step(2'd0, 1'b0, 32'h0, 1'b1, 4'h0, 1'b0, 12'h0, 12'h040, 5'd0, "R2 pop stored");
    step(2'd0, 1'b0, 32'h0, 1'b1, 4'h0, 1'b0, 12'h0, 12'h040, 5'd0, "R7 empty read");

    // events and clear collisions
    step(2'd0, 1'b0, 32'h0, 1'b0, 4'hF, 1'b0, 12'h0, 12'h000, 5'd0, "R8 all events");
    step(2'd0, 1'b0, 32'h0, 1'b0, 4'h1, 1'b1, 12'h300, 12'h100, 5'd0, "R9 set wins over clear");
    step(2'd0, 1'b0, 32'h0, 1'b0, 4'h0, 1'b1, 12'h000, 12'h800, 5'd0, "R9 zero clear no effect");
    step(2'd0, 1'b0, 32'h0, 1'b0, 4'h0, 1'b1, 12'hFFF, 12'hFFF, 5'd0, "R9 R10 clear all");

    // mode change flush with write and read in the same cycle
    step(2'd0, 1'b1, 32'h0000_0011, 1'b0, 4'h0, 1'b0, 12'h0, 12'hFFF, 5'd0, "R11 pre");
    step(2'd1, 1'b1, 32'hFFFF_FFFF, 1'b1, 4'h0, 1'b0, 12'h0, 12'hFFF, 5'd0, "R11 flush");
    for (int i = 0; i < DEPTH / 2 + 1; i++)
      step(2'd1, 1'b1, 32'hBEEF_0000 + 32'(i), 1'b0, 4'h0, 1'b0, 12'h0, 12'h008, 5'd7, "R3 mode1 fill");
    step(2'd1, 1'b0, 32'h0, 1'b1, 4'h0, 1'b0, 12'h0, 12'h001, 5'd6, "R3 mode1 read");

    for (int m = 2; m < 4; m++) begin
      step(2'(m), 1'b0, 32'h0, 1'b0, 4'h0, 1'b1, 12'hFFF, 12'hFFF, 5'd0, "R11 flush");
      for (int i = 0; i < DEPTH / 4 + 1; i++)
        step(2'(m), 1'b1, 32'hC0DE_0000 + 32'(i * 3), 1'b0, 4'h0, 1'b0, 12'h0, 12'h028, 5'd2, "R3 mode2 fill");
      step(2'(m), 1'b0, 32'h0, 1'b1, 4'h0, 1'b0, 12'h0, 12'h001, 5'd2, "R3 mode2 read");
    end

    // seeded random mix
    for (int n = 0; n < 3000; n++) begin
      logic [1:0] md;
      logic [4:0] tl;
      md = (($urandom % 64) == 0) ? 2'($urandom) : mMode;
      tl = 5'($urandom % (DEPTH + 1));
      step(md, ($urandom % 2) == 0, $urandom, ($urandom % 3) == 0,
           (($urandom % 8) == 0) ? 4'($urandom) : 4'h0,
           ($urandom % 6) == 0, 12'($urandom), 12'($urandom), tl,
           "random R2 R4 R5 R8 R10");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule